// File: doc/BRIEF.md
# PWM Channel with Boundary-Deferred Update

This block drives one pulse-width-modulated output from a small memory-mapped register set. Software picks a count rate, an alignment (edge or center), an idle polarity, a duty value and a period value. It then starts and stops the channel with two strobe inputs. While the channel runs, the counter advances on each rate tick. The output stays at its active level for as long as the counter is below the duty value.

Changing the waveform while it runs goes through a single shadow register. A mode bit steers a value written there to either the period or the duty. The value is applied only at the next period boundary, so a running waveform never shows a partial or malformed cycle. A one-cycle interrupt pulse marks each boundary. The rate tick comes from a power-of-two divider of the block clock, or from one of two tick inputs supplied by logic outside the block.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset every register reads 0, the channel is disabled, `pwm_out` is 0 and `period_irq` is 0.
- R2: Register offsets are 0x00 config, 0x04 duty, 0x08 period, 0x0C counter and 0x10 shadow. The config readback holds only bits 10, 9, 8 and 3:0; all other config bits read 0. Duty, period and shadow hold CNT_W bits. A write to 0x0C never changes the counter.
- R3: Config bits [3:0] = n with 0 ≤ n ≤ 10 select a tick every 2^n clocks. After the enable edge the counter first advances at the 2^n-th clock edge, so k edges after enable the counter reads floor(k / 2^n), as long as it stays below the period.
- R4: Rate code 0xB advances the counter once per clock on which `alt_tick_a` is high, and code 0xC does the same with `alt_tick_b`. The tick input that is not selected has no effect. Codes 0xD to 0xF never advance the counter.
- R5: With config bit 8 clear (edge mode) and period P ≥ 1, the counter steps 0, 1, …, P−1 and then returns to 0. The output is active while counter < duty and idle otherwise.
- R6: With config bit 8 set (center mode), the counter climbs from 0 to P, then falls back to 0. One cycle lasts 2·P ticks, and the boundary is the tick that returns the counter to 0.
- R7: With config bit 9 clear, the idle level is 0 and the active level is 1. With bit 9 set, both levels are inverted.
- R8: A write to the shadow register (0x10) is applied at the next period boundary. It goes to the period if config bit 10 is set and to the duty if bit 10 is clear. Until that boundary, the old value stays in force and is what the register reads back.
- R9: `period_irq` is high for exactly the one clock after each boundary edge while the channel is enabled, and the counter reads 0 in that clock.
- R10: While the channel is enabled, writes to config, duty and period are ignored.
- R11: `chan_on` enables the channel and `chan_off` disables it; `chan_off` wins if both are high. From the disable edge onward, the output holds the idle level and the counter reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the source of the power-of-two rates |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the register at `reg_addr` (combinational) |
| chan_on | input | 1 | Enable strobe |
| chan_off | input | 1 | Disable strobe (wins over enable) |
| alt_tick_a | input | 1 | External tick for rate code 0xB |
| alt_tick_b | input | 1 | External tick for rate code 0xC |
| pwm_out | output | 1 | Waveform output |
| period_irq | output | 1 | One-clock pulse after each period boundary |

## Verification
The checker assumes that all inputs change synchronously to `clk`. It also assumes that the period changes only while the counter sits at zero, either through a direct write while disabled or through a shadow update at a boundary. Its counter-bound property depends on this. The stimulus keeps to these assumptions: it programs config, duty and period only after a disable strobe, and during a run it changes the waveform only through the shadow register. The external tick inputs are driven as single-clock pulses on falling edges, so each one is seen by exactly one rising edge.

// File: rtl/pwm_shadow_pkg.sv
`timescale 1ns/1ps
package pwm_shadow_pkg;
   localparam int ADDR_W = 5;

   localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_DUTY = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_PRD  = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_SHD  = 5'h10;

   localparam logic [3:0] RATE_EXT_A = 4'hB;
   localparam logic [3:0] RATE_EXT_B = 4'hC;

   // bit positions inside the config word
   localparam int POS_CENTER = 8;
   localparam int POS_POL    = 9;
   localparam int POS_TO_PRD = 10;

   typedef struct packed {
      logic       to_prd;
      logic       pol;
      logic       center;
      logic [3:0] rate;
   } cfg_t;
endpackage

// File: rtl/pwm_rate_sel.sv
`timescale 1ns/1ps
module pwm_rate_sel
   import pwm_shadow_pkg::*;
#(
   parameter int MAX_LOG2 = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [3:0] rate,
   input  logic       ext_a,
   input  logic       ext_b,
   output logic       tick
);
   initial begin
      assert (MAX_LOG2 >= 1 && MAX_LOG2 <= 10)
         else $error("pwm_rate_sel: MAX_LOG2 must be 1..10");
   end

   logic [MAX_LOG2-1:0] div_q;
   logic [MAX_LOG2:0]   pow_tick;
   logic                sel_tick;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) div_q <= '0;
      else                div_q <= div_q + 1'b1;
   end

   genvar g;
   generate
      for (g = 0; g <= MAX_LOG2; g++) begin : g_pow
         if (g == 0) begin : g_every
            assign pow_tick[g] = 1'b1;
         end else begin : g_div
            assign pow_tick[g] = &div_q[g-1:0];
         end
      end
   endgenerate

   always_comb begin
      sel_tick = 1'b0;
      for (int i = 0; i <= MAX_LOG2; i++) begin
         if (rate == i[3:0]) sel_tick = pow_tick[i];
      end
      if (rate == RATE_EXT_A) sel_tick = ext_a;
      if (rate == RATE_EXT_B) sel_tick = ext_b;
   end

   assign tick = run && sel_tick;
endmodule

// File: rtl/pwm_wave_core.sv
`timescale 1ns/1ps
module pwm_wave_core #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             center,
   input  logic [CNT_W-1:0] prd,
   input  logic [CNT_W-1:0] duty,
   output logic [CNT_W-1:0] cnt,
   output logic             boundary,
   output logic             active
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             down_q, down_d;
   logic             wrap;

   always_comb begin
      cnt_d  = cnt_q;
      down_d = down_q;
      wrap   = 1'b0;
      if (tick) begin
         if (!center) begin
            if (prd == '0 || cnt_q >= prd - ONE) begin
               cnt_d = '0;
               wrap  = 1'b1;
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end else if (prd == '0) begin
            cnt_d  = '0;
            down_d = 1'b0;
            wrap   = 1'b1;
         end else if (!down_q) begin
            if (cnt_q >= prd) begin
               if (cnt_q <= ONE) begin
                  cnt_d = '0;
                  wrap  = 1'b1;
               end else begin
                  cnt_d  = cnt_q - ONE;
                  down_d = 1'b1;
               end
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end else begin
            if (cnt_q <= ONE) begin
               cnt_d  = '0;
               down_d = 1'b0;
               wrap   = 1'b1;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q  <= '0;
         down_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         down_q <= down_d;
      end
   end

   assign cnt      = cnt_q;
   assign boundary = run && wrap;
   assign active   = cnt_q < duty;
endmodule

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
   import pwm_shadow_pkg::*;
#(
   parameter int CNT_W  = 20,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enabled,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              boundary,
   input  logic [CNT_W-1:0]  cnt,
   output cfg_t              cfg,
   output logic [CNT_W-1:0]  duty,
   output logic [CNT_W-1:0]  prd,
   output logic [DATA_W-1:0] rdata
);
   logic [CNT_W-1:0] shd_q;
   logic             pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg    <= '0;
         duty   <= '0;
         prd    <= '0;
         shd_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (wr && !enabled) begin
            case (addr)
               OFS_CFG: begin
                  cfg.to_prd <= wdata[POS_TO_PRD];
                  cfg.pol    <= wdata[POS_POL];
                  cfg.center <= wdata[POS_CENTER];
                  cfg.rate   <= wdata[3:0];
               end
               OFS_DUTY: duty <= wdata[CNT_W-1:0];
               OFS_PRD:  prd  <= wdata[CNT_W-1:0];
               default: ;
            endcase
         end
         if (boundary && pend_q) begin
            if (cfg.to_prd) prd  <= shd_q;
            else            duty <= shd_q;
            pend_q <= 1'b0;
         end
         if (wr && addr == OFS_SHD) begin
            shd_q  <= wdata[CNT_W-1:0];
            pend_q <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_CFG: begin
            rdata[POS_TO_PRD] = cfg.to_prd;
            rdata[POS_POL]    = cfg.pol;
            rdata[POS_CENTER] = cfg.center;
            rdata[3:0]        = cfg.rate;
         end
         OFS_DUTY: rdata[CNT_W-1:0] = duty;
         OFS_PRD:  rdata[CNT_W-1:0] = prd;
         OFS_CNT:  rdata[CNT_W-1:0] = cnt;
         OFS_SHD:  rdata[CNT_W-1:0] = shd_q;
         default: ;
      endcase
   end

   logic unused_wdata;
   generate
      if (DATA_W > CNT_W) begin : g_hi
         assign unused_wdata = ^wdata[DATA_W-1:CNT_W];
      end else begin : g_nohi
         assign unused_wdata = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwm_shadow_chan.sv
`timescale 1ns/1ps
module pwm_shadow_chan
   import pwm_shadow_pkg::*;
#(
   parameter int CNT_W    = 20,
   parameter int MAX_LOG2 = 10,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [4:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              chan_on,
   input  logic              chan_off,
   input  logic              alt_tick_a,
   input  logic              alt_tick_b,
   output logic              pwm_out,
   output logic              period_irq
);
   initial begin
      assert (CNT_W >= 2 && CNT_W <= DATA_W)
         else $error("pwm_shadow_chan: CNT_W must be 2..DATA_W");
      assert (DATA_W >= 11)
         else $error("pwm_shadow_chan: DATA_W must hold the config word");
   end

   logic             en_q, run, tick, boundary, active, irq_q;
   cfg_t             mode_q;
   logic [CNT_W-1:0] duty_q, prd_q, cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (chan_off)     en_q <= 1'b0;
         else if (chan_on) en_q <= 1'b1;
         irq_q <= boundary;
      end
   end

   assign run = en_q && !chan_off;

   pwm_rate_sel #(.MAX_LOG2(MAX_LOG2)) u_rate (
      .clk(clk), .rst_n(rst_n), .run(run), .rate(mode_q.rate),
      .ext_a(alt_tick_a), .ext_b(alt_tick_b), .tick(tick)
   );

   pwm_wave_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
      .center(mode_q.center), .prd(prd_q), .duty(duty_q),
      .cnt(cnt_q), .boundary(boundary), .active(active)
   );

   pwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .enabled(en_q), .wr(reg_wr),
      .addr(reg_addr), .wdata(reg_wdata), .boundary(boundary),
      .cnt(cnt_q), .cfg(mode_q), .duty(duty_q), .prd(prd_q),
      .rdata(reg_rdata)
   );

   assign pwm_out    = (en_q && active) ? !mode_q.pol : mode_q.pol;
   assign period_irq = irq_q;
endmodule

// File: rtl/pwm_shadow_chan_chk.sv
`timescale 1ns/1ps
module pwm_shadow_chan_chk
   import pwm_shadow_pkg::*;
#(
   parameter int CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_q,
   input logic             boundary,
   input cfg_t             mode_q,
   input logic [CNT_W-1:0] duty_q,
   input logic [CNT_W-1:0] prd_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             pwm_out,
   input logic             period_irq,
   input logic             reg_wr,
   input logic [4:0]       reg_addr
);
   // R11: a stopped channel sits at its idle level
   a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> pwm_out == mode_q.pol);

   // R9: the interrupt clock sees a zero counter
   a_r9_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      period_irq |-> cnt_q == '0);

   // R9: no interrupt unless the channel ran in the clock before
   a_r9_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      period_irq |-> $past(en_q));

   // R10: config is frozen against writes while running
   a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && reg_wr && reg_addr == OFS_CFG) |=> $stable(mode_q));

   // R8: running values move only at a boundary
   a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !boundary) |=> ($stable(duty_q) && $stable(prd_q)));

   // R5 and R6: counter never passes the period
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> (cnt_q <= prd_q || cnt_q == '0));
endmodule

bind pwm_shadow_chan pwm_shadow_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_q(en_q), .boundary(boundary),
   .mode_q(mode_q), .duty_q(duty_q), .prd_q(prd_q), .cnt_q(cnt_q),
   .pwm_out(pwm_out), .period_irq(period_irq), .reg_wr(reg_wr),
   .reg_addr(reg_addr)
);

// File: tb/pwm_shadow_chan_tb.sv
`timescale 1ns/1ps
module pwm_shadow_chan_tb;
   localparam logic [4:0] A_CFG = 5'h00, A_DUTY = 5'h04, A_PRD = 5'h08,
                          A_CNT = 5'h0C, A_SHD = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        chan_on = 1'b0, chan_off = 1'b0;
   logic        alt_tick_a = 1'b0, alt_tick_b = 1'b0;
   logic        pwm_out, period_irq;

   int n_total = 0;
   int n_bad   = 0;
   bit done    = 1'b0;

   always #10 clk = !clk;

   pwm_shadow_chan u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_on(chan_on),
      .chan_off(chan_off), .alt_tick_a(alt_tick_a), .alt_tick_b(alt_tick_b),
      .pwm_out(pwm_out), .period_irq(period_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic turn_on();
      chan_on = 1'b1; @(negedge clk); chan_on = 1'b0;
   endtask

   task automatic turn_off();
      chan_off = 1'b1; @(negedge clk); chan_off = 1'b0;
   endtask

   task automatic setup(input logic [31:0] cfg, input int prd, input int duty);
      wr_reg(A_CFG, cfg); wr_reg(A_PRD, prd); wr_reg(A_DUTY, duty);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd_reg(A_CFG, v);  chk("R1 cfg", v, 0);
      rd_reg(A_DUTY, v); chk("R1 duty", v, 0);
      rd_reg(A_PRD, v);  chk("R1 prd", v, 0);
      rd_reg(A_CNT, v);  chk("R1 cnt", v, 0);
      chk("R1 out", pwm_out, 0);
      chk("R1 irq", period_irq, 0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wr_reg(A_CFG, 32'hFFFF_FFFF); rd_reg(A_CFG, v); chk("R2 cfg bits", v, 32'h70F);
      wr_reg(A_DUTY, 32'hFFFF_FFFF); rd_reg(A_DUTY, v); chk("R2 duty width", v, 32'hFFFFF);
      wr_reg(A_PRD, 32'h0001_2345); rd_reg(A_PRD, v); chk("R2 prd", v, 32'h12345);
      wr_reg(A_CNT, 32'd55); rd_reg(A_CNT, v); chk("R2 cnt readonly", v, 0);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      setup(32'h0, 5, 2);
      turn_on();
      for (int k = 0; k < 12; k++) begin
         rd_reg(A_CNT, v);
         chk("R5 edge cnt", v, k % 5);
         chk("R5 edge out", pwm_out, (k % 5) < 2);
         chk("R9 edge irq", period_irq, (k > 0 && k % 5 == 0));
         step(1);
      end
      turn_off();
      rd_reg(A_CNT, v);
      chk("R11 off cnt", v, 0);
      chk("R11 off out", pwm_out, 0);
   endtask

   task automatic t_polarity();
      setup(32'h200, 3, 1);
      chk("R7 idle high while off", pwm_out, 1);
      turn_on();
      chk("R7 active low", pwm_out, 0);
      step(1);
      chk("R7 idle high in run", pwm_out, 1);
      turn_off();
      chk("R7 idle after off", pwm_out, 1);
   endtask

   task automatic t_center();
      logic [31:0] v;
      int seq [6] = '{0, 1, 2, 3, 2, 1};
      setup(32'h100, 3, 2);
      turn_on();
      for (int k = 0; k < 14; k++) begin
         rd_reg(A_CNT, v);
         chk("R6 center cnt", v, seq[k % 6]);
         chk("R6 center out", pwm_out, seq[k % 6] < 2);
         chk("R9 center irq", period_irq, (k > 0 && k % 6 == 0));
         step(1);
      end
      turn_off();
   endtask

   task automatic t_rate();
      logic [31:0] v;
      setup(32'h2, 100, 0);
      turn_on();
      for (int k = 0; k < 13; k++) begin
         rd_reg(A_CNT, v);
         chk("R3 div4 cnt", v, k / 4);
         step(1);
      end
      turn_off();
   endtask

   task automatic pulse_a();
      alt_tick_a = 1'b1; @(negedge clk); alt_tick_a = 1'b0;
   endtask

   task automatic pulse_b();
      alt_tick_b = 1'b1; @(negedge clk); alt_tick_b = 1'b0;
   endtask

   task automatic t_ext();
      logic [31:0] v;
      setup(32'hB, 100, 0);
      turn_on();
      for (int i = 0; i < 3; i++) begin pulse_a(); pulse_b(); pulse_b(); end
      rd_reg(A_CNT, v); chk("R4 ext A count", v, 3);
      turn_off();
      setup(32'hC, 100, 0);
      turn_on();
      for (int i = 0; i < 2; i++) begin pulse_b(); pulse_a(); pulse_a(); end
      rd_reg(A_CNT, v); chk("R4 ext B count", v, 2);
      turn_off();
      setup(32'hD, 100, 0);
      turn_on();
      pulse_a(); pulse_b(); step(3);
      rd_reg(A_CNT, v); chk("R4 code D frozen", v, 0);
      turn_off();
   endtask

   task automatic t_shadow_duty();
      logic [31:0] v;
      setup(32'h0, 4, 1);
      turn_on();
      step(1);
      wr_reg(A_SHD, 3);                 // lands at edge 2
      rd_reg(A_DUTY, v); chk("R8 duty deferred", v, 1);
      chk("R8 old duty out", pwm_out, 0);
      step(1);
      rd_reg(A_DUTY, v); chk("R8 duty still old", v, 1);
      step(1);                          // edge 4 is the boundary
      rd_reg(A_DUTY, v); chk("R8 duty applied", v, 3);
      rd_reg(A_SHD, v);  chk("R2 shadow readback", v, 3);
      step(2);
      chk("R8 new duty out", pwm_out, 1);
      step(1);
      chk("R8 new duty idle", pwm_out, 0);
      turn_off();
   endtask

   task automatic t_shadow_prd();
      logic [31:0] v;
      setup(32'h400, 4, 0);
      turn_on();
      wr_reg(A_SHD, 6);                 // lands at edge 1
      for (int k = 1; k <= 10; k++) begin
         chk("R8 prd irq timing", period_irq, (k == 4 || k == 10));
         if (k == 3) begin rd_reg(A_PRD, v); chk("R8 prd deferred", v, 4); end
         if (k == 5) begin rd_reg(A_PRD, v); chk("R8 prd applied", v, 6); end
         step(1);
      end
      // still running: locked registers
      wr_reg(A_CFG, 32'h100);
      wr_reg(A_DUTY, 7);
      wr_reg(A_PRD, 9);
      rd_reg(A_CFG, v);  chk("R10 cfg locked", v, 32'h400);
      rd_reg(A_DUTY, v); chk("R10 duty locked", v, 0);
      rd_reg(A_PRD, v);  chk("R10 prd locked", v, 6);
      wr_reg(A_CNT, 55);
      rd_reg(A_CNT, v);  chk("R2 cnt write ignored", v < 6, 1);
      turn_off();
   endtask

   task automatic t_off_wins();
      logic [31:0] v;
      setup(32'h0, 5, 3);
      chan_on = 1'b1; chan_off = 1'b1;
      step(1);
      chan_on = 1'b0; chan_off = 1'b0;
      step(3);
      rd_reg(A_CNT, v);
      chk("R11 off wins cnt", v, 0);
      chk("R11 off wins out", pwm_out, 0);
      chk("R11 off wins irq", period_irq, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_total++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_regmap();
      t_edge();
      t_polarity();
      t_center();
      t_rate();
      t_ext();
      t_shadow_duty();
      t_shadow_prd();
      t_off_wins();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end
endmodule